// File: doc/BRIEF.md
# DRAM Rank Power-State Controller

This block drives the clock-enable line of each rank on a DDR3 channel and keeps track of each rank's power state. Every rank has its own state machine. When a rank is up and sees no traffic for a programmed number of cycles, it powers down. It picks precharge power-down when all of its banks are closed and active power-down when any bank is still open. When the package is in a deep low-power state and the rank has no request pending, the rank goes into self-refresh. To get there it first asks the external command scheduler to precharge all banks, then asks for self-refresh entry. Each of these steps is a request/acknowledge handshake.

A request to a powered-down rank raises its clock enable at once. The command permit stays low until a programmed exit delay has run out. A rank in self-refresh leaves it when a request arrives or when the deep package state ends, and it returns to the powered-up state only after the scheduler acknowledges the exit. A rank that is marked as not populated keeps its clock enable low and stays inactive. Command timing, refresh scheduling and the PHY sit outside this block.

Top module: `dram_rank_pwr_ctl`

## Requirements
- R1: During reset every rank reports state code 0 (inactive), with clock enable, command permit and all three request strobes low. On the first clock edge after reset is released, a populated rank moves to code 1 (up) with clock enable and command permit high.
- R2: A rank in code 1 powers down on the clock edge that ends its `idle_thresh_i`-th consecutive cycle with no request (a threshold of 0 acts as 1). Any request clears the count.
- R3: A rank powering down enters code 2 (precharge power-down) when its bank-open input is low and code 3 (active power-down) when it is high. Clock enable is low in both.
- R4: A request to a rank in code 2 or 3 moves it to code 4 (waking) on the next edge, with clock enable high and command permit low. The rank stays in code 4 for exactly `exit_dly_i`+1 cycles and then returns to code 1.
- R5: A rank in code 1 with `deep_pkg_i` high and no request moves to code 5 (precharging). It holds clock enable high and holds its precharge-all request high until that request is acknowledged.
- R6: When the precharge-all acknowledge arrives, the rank moves to code 6 (entering self-refresh) and holds its self-refresh-entry request high until acknowledged. It then moves to code 7 (self-refresh) with clock enable low and no strobe active.
- R7: In code 7, a request or a low `deep_pkg_i` moves the rank to code 8 (exiting self-refresh). In code 8 clock enable is high, command permit is low, and the self-refresh-exit request is held until acknowledged; the rank then returns to code 1.
- R8: A rank in code 2 or 3 that sees `deep_pkg_i` high with no request first wakes through code 4, so self-refresh entry always starts from code 1.
- R9: A rank whose populated input is low enters code 0 on the next edge and stays there with clock enable, command permit and strobes low, whatever its other inputs do.
- R10: Ranks are independent: one rank's requests, bank state and acknowledges do not change another rank's state.
- R11: Command permit is high only in code 1, and it rises only when leaving code 4, code 8 or code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rank_present_i | input | NUM_RANKS | Rank is populated |
| rank_req_i | input | NUM_RANKS | Access pending for the rank |
| bank_open_i | input | NUM_RANKS | At least one bank of the rank is open |
| deep_pkg_i | input | 1 | Package is in a deep low-power state |
| idle_thresh_i | input | IDLE_W | Idle cycles before power-down |
| exit_dly_i | input | DLY_W | Extra cycles of wake-up delay |
| pre_all_ack_i | input | NUM_RANKS | Precharge-all acknowledge |
| sr_enter_ack_i | input | NUM_RANKS | Self-refresh entry acknowledge |
| sr_exit_ack_i | input | NUM_RANKS | Self-refresh exit acknowledge |
| cke_o | output | NUM_RANKS | Clock enable per rank |
| cmd_ok_o | output | NUM_RANKS | Rank may take a command |
| pre_all_req_o | output | NUM_RANKS | Precharge-all request |
| sr_enter_req_o | output | NUM_RANKS | Self-refresh entry request |
| sr_exit_req_o | output | NUM_RANKS | Self-refresh exit request |
| rank_state_o | output | 4*NUM_RANKS | State code of rank r at bits 4r+3:4r |

## Verification
The assertions check the following on every cycle:
- An unpopulated rank falls to inactive with clock enable low.
- Power-down never picks the precharge variant while a bank is open, and never picks the active variant while all banks are closed.
- Every request strobe stays high until its acknowledge.
- Self-refresh entry is requested only right after an acknowledged precharge-all.
- The wake state is not left before the delay runs out.
- The idle count clears on a request.

Only the bench's scenarios can show the exact cycle counts: the idle threshold and the wake delay. They also show the full self-refresh round trip through both exit causes, the detour from power-down through waking under a deep package state, and the independence of the two ranks.

// File: rtl/dram_pwr_pkg.sv
package dram_pwr_pkg;
  localparam int unsigned ST_W = 4;
  typedef enum logic [ST_W-1:0] {
    ST_INACT = 4'd0,
    ST_UP    = 4'd1,
    ST_PPD   = 4'd2,
    ST_APD   = 4'd3,
    ST_WAKE  = 4'd4,
    ST_PREA  = 4'd5,
    ST_SRE   = 4'd6,
    ST_SR    = 4'd7,
    ST_SRX   = 4'd8
  } rank_st_e;
endpackage

// File: rtl/rank_idle_timer.sv
module rank_idle_timer #(
  parameter int unsigned IDLE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              req_i,
  input  logic [IDLE_W-1:0] thresh_i,
  output logic              hit_o
);
  logic [IDLE_W-1:0] cnt_q;
  logic [IDLE_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + {{IDLE_W{1'b0}}, 1'b1};
  // fires on the thresh-th consecutive idle cycle
  assign hit_o  = run_i && !req_i && (cnt_nx >= {1'b0, thresh_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || req_i)    cnt_q <= '0;
    else if (cnt_q != '1)        cnt_q <= cnt_q + 1'b1;
  end

  AST_IDLE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/rank_pwr_fsm.sv
module rank_pwr_fsm
  import dram_pwr_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             present_i,
  input  logic             req_i,
  input  logic             bank_open_i,
  input  logic             deep_i,
  input  logic             idle_hit_i,
  input  logic [DLY_W-1:0] exit_dly_i,
  input  logic             pre_all_ack_i,
  input  logic             sr_enter_ack_i,
  input  logic             sr_exit_ack_i,
  output rank_st_e         state_o,
  output logic             cke_o,
  output logic             cmd_ok_o,
  output logic             pre_all_req_o,
  output logic             sr_enter_req_o,
  output logic             sr_exit_req_o
);
  rank_st_e         st_q, st_d;
  logic [DLY_W-1:0] dly_q;

  always_comb begin
    st_d = st_q;
    if (!present_i) st_d = ST_INACT;
    else begin
      unique case (st_q)
        ST_INACT: st_d = ST_UP;
        ST_UP: begin
          if (deep_i && !req_i)  st_d = ST_PREA;
          else if (idle_hit_i)   st_d = bank_open_i ? ST_APD : ST_PPD;
        end
        ST_PPD, ST_APD: if (req_i || deep_i) st_d = ST_WAKE;
        ST_WAKE: if (dly_q >= exit_dly_i) st_d = ST_UP;
        ST_PREA: if (pre_all_ack_i)  st_d = ST_SRE;
        ST_SRE:  if (sr_enter_ack_i) st_d = ST_SR;
        ST_SR:   if (req_i || !deep_i) st_d = ST_SRX;
        ST_SRX:  if (sr_exit_ack_i)  st_d = ST_UP;
        default: st_d = ST_INACT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_INACT;
      dly_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q != ST_WAKE)   dly_q <= '0;
      else if (dly_q != '1)  dly_q <= dly_q + 1'b1;
    end
  end

  assign state_o        = st_q;
  assign cke_o          = (st_q == ST_UP) || (st_q == ST_WAKE) || (st_q == ST_PREA) ||
                          (st_q == ST_SRE) || (st_q == ST_SRX);
  assign cmd_ok_o       = (st_q == ST_UP);
  assign pre_all_req_o  = (st_q == ST_PREA);
  assign sr_enter_req_o = (st_q == ST_SRE);
  assign sr_exit_req_o  = (st_q == ST_SRX);

  AST_UNPOP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_i |=> (st_q == ST_INACT && !cke_o)); // R9
  AST_PPD_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UP && bank_open_i) |=> (st_q != ST_PPD)); // R3
  AST_APD_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UP && !bank_open_i) |=> (st_q != ST_APD)); // R3
  AST_WAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_i && st_q == ST_WAKE && dly_q < exit_dly_i) |=> (st_q == ST_WAKE)); // R4
  AST_PREA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_i && pre_all_req_o && !pre_all_ack_i) |=> pre_all_req_o); // R5
  AST_SRE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_i && sr_enter_req_o && !sr_enter_ack_i) |=> sr_enter_req_o); // R6
  AST_SR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sr_enter_req_o) |-> $past(pre_all_req_o && pre_all_ack_i)); // R6
  AST_SRX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_i && sr_exit_req_o && !sr_exit_ack_i) |=> sr_exit_req_o); // R7
  AST_CMD_OK_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_ok_o) |-> ($past(st_q) == ST_WAKE || $past(st_q) == ST_SRX ||
                         $past(st_q) == ST_INACT)); // R11
endmodule

// File: rtl/dram_rank_pwr_ctl.sv
module dram_rank_pwr_ctl
  import dram_pwr_pkg::*;
#(
  parameter int unsigned NUM_RANKS = 2,
  parameter int unsigned IDLE_W    = 16,
  parameter int unsigned DLY_W     = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_RANKS-1:0]      rank_present_i,
  input  logic [NUM_RANKS-1:0]      rank_req_i,
  input  logic [NUM_RANKS-1:0]      bank_open_i,
  input  logic                      deep_pkg_i,
  input  logic [IDLE_W-1:0]         idle_thresh_i,
  input  logic [DLY_W-1:0]          exit_dly_i,
  input  logic [NUM_RANKS-1:0]      pre_all_ack_i,
  input  logic [NUM_RANKS-1:0]      sr_enter_ack_i,
  input  logic [NUM_RANKS-1:0]      sr_exit_ack_i,
  output logic [NUM_RANKS-1:0]      cke_o,
  output logic [NUM_RANKS-1:0]      cmd_ok_o,
  output logic [NUM_RANKS-1:0]      pre_all_req_o,
  output logic [NUM_RANKS-1:0]      sr_enter_req_o,
  output logic [NUM_RANKS-1:0]      sr_exit_req_o,
  output logic [ST_W*NUM_RANKS-1:0] rank_state_o
);
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    rank_st_e st;
    logic     hit;

    rank_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (st == ST_UP),
      .req_i    (rank_req_i[r]),
      .thresh_i (idle_thresh_i),
      .hit_o    (hit)
    );

    rank_pwr_fsm #(.DLY_W(DLY_W)) u_fsm (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .present_i      (rank_present_i[r]),
      .req_i          (rank_req_i[r]),
      .bank_open_i    (bank_open_i[r]),
      .deep_i         (deep_pkg_i),
      .idle_hit_i     (hit),
      .exit_dly_i     (exit_dly_i),
      .pre_all_ack_i  (pre_all_ack_i[r]),
      .sr_enter_ack_i (sr_enter_ack_i[r]),
      .sr_exit_ack_i  (sr_exit_ack_i[r]),
      .state_o        (st),
      .cke_o          (cke_o[r]),
      .cmd_ok_o       (cmd_ok_o[r]),
      .pre_all_req_o  (pre_all_req_o[r]),
      .sr_enter_req_o (sr_enter_req_o[r]),
      .sr_exit_req_o  (sr_exit_req_o[r])
    );

    assign rank_state_o[r*ST_W +: ST_W] = st;
  end
endmodule

// File: tb/dram_rank_pwr_ctl_test.sv
module dram_rank_pwr_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  present, req, bopen, pa_ack, sre_ack, srx_ack;
  logic        deep;
  logic [15:0] thresh;
  logic [7:0]  dly;
  logic [1:0]  cke, cok, pa_req, sre_req, srx_req;
  logic [7:0]  st_w;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  dram_rank_pwr_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .rank_present_i(present), .rank_req_i(req),
    .bank_open_i(bopen), .deep_pkg_i(deep), .idle_thresh_i(thresh), .exit_dly_i(dly),
    .pre_all_ack_i(pa_ack), .sr_enter_ack_i(sre_ack), .sr_exit_ack_i(srx_ack),
    .cke_o(cke), .cmd_ok_o(cok), .pre_all_req_o(pa_req), .sr_enter_req_o(sre_req),
    .sr_exit_req_o(srx_req), .rank_state_o(st_w)
  );

  // rows: idle threshold, bank open, exit delay, expected power-down code
  localparam int TBL [5][4] = '{
    '{3, 0, 2, 2}, '{5, 1, 0, 3}, '{1, 0, 4, 2}, '{0, 1, 1, 3}, '{7, 1, 3, 3}
  };

  function automatic logic [3:0] rs(int r);
    return st_w[4*r +: 4];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack(ref logic [1:0] a, input int r);
    a[r] = 1'b1;
    step();
    a[r] = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    present = 2'b11; req = 2'b10; bopen = 2'b00; deep = 1'b0;
    thresh = 16'd1000; dly = 8'd0; pa_ack = '0; sre_ack = '0; srx_ack = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rst state", st_w, 8'h00);
    check("R1 rst cke", cke, 2'b00);
    check("R1 rst cmd_ok", cok, 2'b00);
    check("R1 rst strobes", {pa_req, sre_req, srx_req}, 6'b0);
    rst_n = 1'b1;
    step();
    check("R1 up state", st_w, 8'h11);
    check("R1 up cke/cmd_ok", {cke, cok}, 4'b1111);

    // R2 R3 R4 table walk on rank 0
    for (int i = 0; i < 5; i++) begin
      int eff;
      eff = (TBL[i][0] == 0) ? 1 : TBL[i][0];
      thresh = 16'(TBL[i][0]); bopen[0] = TBL[i][1][0]; dly = 8'(TBL[i][2]);
      req[0] = 1'b1;
      step();
      req[0] = 1'b0;
      repeat (eff - 1) step();
      check("R2 before thresh", rs(0), 4'd1);
      step();
      check("R3 pd code", rs(0), 4'(TBL[i][3]));
      check("R3 pd cke low", cke[0], 1'b0);
      req[0] = 1'b1;
      step();
      check("R4 wake code", rs(0), 4'd4);
      check("R4 wake cke/cmd_ok", {cke[0], cok[0]}, 2'b10);
      repeat (TBL[i][2]) step();
      check("R4 still wake", rs(0), 4'd4);
      step();
      check("R4 back up", {rs(0), cok[0]}, {4'd1, 1'b1});
    end
    check("R10 rank1 untouched", rs(1), 4'd1);

    // R2 count cleared mid-way
    thresh = 16'd4; bopen[0] = 1'b0; dly = 8'd0;
    req[0] = 1'b0;
    repeat (3) step();
    check("R2 3 of 4 idle", rs(0), 4'd1);
    req[0] = 1'b1; step(); req[0] = 1'b0;
    repeat (3) step();
    check("R2 cleared count", rs(0), 4'd1);
    step();
    check("R2 after clear pd", rs(0), 4'd2);

    // R8 deep while in power-down
    deep = 1'b1;
    step();
    check("R8 pd to wake", rs(0), 4'd4);
    thresh = 16'd1000;
    step();
    check("R8 wake to up", rs(0), 4'd1);
    step();
    // R5
    check("R5 prea code", rs(0), 4'd5);
    check("R5 prea req/cke", {pa_req[0], cke[0], cok[0]}, 3'b110);
    check("R10 rank1 busy stays up", rs(1), 4'd1);
    repeat (3) step();
    check("R5 prea held", {rs(0), pa_req[0]}, {4'd5, 1'b1});
    pulse_ack(pa_ack, 0);
    // R6
    check("R6 sre code", {rs(0), sre_req[0], pa_req[0]}, {4'd6, 2'b10});
    repeat (2) step();
    check("R6 sre held", {rs(0), sre_req[0]}, {4'd6, 1'b1});
    pulse_ack(sre_ack, 0);
    check("R6 sr code", {rs(0), cke[0]}, {4'd7, 1'b0});
    check("R6 sr no strobes", {pa_req[0], sre_req[0], srx_req[0]}, 3'b000);
    repeat (3) step();
    check("R6 sr stays", rs(0), 4'd7);
    // R7 exit on deep drop
    deep = 1'b0;
    step();
    check("R7 srx code", {rs(0), cke[0], cok[0], srx_req[0]}, {4'd8, 3'b101});
    step();
    check("R7 srx held", {rs(0), srx_req[0]}, {4'd8, 1'b1});
    pulse_ack(srx_ack, 0);
    check("R7 srx to up", {rs(0), cok[0]}, {4'd1, 1'b1});

    // R7 exit on request
    deep = 1'b1;
    step();
    pulse_ack(pa_ack, 0);
    pulse_ack(sre_ack, 0);
    check("R7 second sr", rs(0), 4'd7);
    req[0] = 1'b1;
    step();
    check("R7 req exits sr", {rs(0), cke[0]}, {4'd8, 1'b1});
    pulse_ack(srx_ack, 0);
    check("R7 up after req exit", rs(0), 4'd1);

    // R9 unpopulated rank, deep still high
    present[1] = 1'b0;
    step();
    check("R9 inactive", {rs(1), cke[1], cok[1]}, {4'd0, 2'b00});
    req[1] = 1'b0; bopen[1] = 1'b1;
    repeat (3) step();
    check("R9 stays inactive", {rs(1), cke[1], pa_req[1], sre_req[1], srx_req[1]}, {4'd0, 4'b0000});
    check("R10 rank0 up with req", rs(0), 4'd1);
    deep = 1'b0; req[1] = 1'b1;
    present[1] = 1'b1;
    step();
    check("R9 repopulated up", {rs(1), cke[1], cok[1]}, {4'd1, 2'b11});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule